// File: doc/BRIEF.md
# Dual-Clock Centred-Window Frame Buffer

This block decouples a slow camera capture path from a faster display raster. The camera side delivers one 16-bit RGB565 word per pixel, with its column and line coordinates and a write strobe, on its own pixel clock. Each word is stored in an on-chip dual-port memory that holds exactly one image. The display side runs on an independent pixel clock and presents the current screen column, screen line and a blanking flag. It gets back the colour of that screen position split into 5-, 6- and 5-bit outputs. The display can therefore scan a frame that has not changed several times while the camera slowly replaces it.

The stored image is smaller than the screen and is placed in the middle of it. Screen positions inside that window show the stored pixel at the matching offset. Every other visible position is black, and so is every position during blanking. The two clock domains share no control signals, so a frame being overwritten while it is displayed can show a tear. The production setting is a 320x240 image on a 640x480 screen, with the window origin at column 160, line 120. The parameter defaults are a scaled copy of that setting, kept small so the block elaborates quickly.

Top module: `fb_qvga_window`

## Requirements
- R1: On a rising write clock edge with the write strobe high and coordinates inside the image, the word is stored at address line*IMG_W + column.
- R2: A write whose column is IMG_W or more, or whose line is IMG_H or more, changes no stored pixel. For example, column IMG_W on line 0 must not alter line 1, column 0.
- R3: The window origin is column (SCR_W-IMG_W)/2, line (SCR_H-IMG_H)/2. A non-blanked screen position inside the IMG_W x IMG_H window shows the stored pixel at (column - origin column, line - origin line). This includes all four window edges.
- R4: A non-blanked screen position outside the window outputs black, meaning all colour bits are zero.
- R5: When the blanking flag is high, the outputs are black, even inside the window.
- R6: The red output is stored bits 15:11, the green output is bits 10:5 and the blue output is bits 4:0.
- R7: The colour for a position presented before read clock edge N appears on the outputs just after edge N+1, and a new position may be presented every cycle.
- R8: A high synchronous read reset drives the outputs to black from the next read clock edge. Stored pixels survive the reset.
- R9: The write and read ports are independent. Reading a frame repeatedly without writes returns the same colours each time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Camera pixel clock |
| wr_en | input | 1 | Write strobe for the current pixel |
| wr_col | input | COORD_W | Image column of the written pixel |
| wr_line | input | COORD_W | Image line of the written pixel |
| wr_data | input | 16 | RGB565 pixel word |
| rd_clk | input | 1 | Display pixel clock |
| rd_rst | input | 1 | Synchronous active-high reset for the read side |
| rd_col | input | COORD_W | Screen column being fetched |
| rd_line | input | COORD_W | Screen line being fetched |
| rd_blank | input | 1 | High while the display is in blanking |
| out_r | output | 5 | Red colour output |
| out_g | output | 6 | Green colour output |
| out_b | output | 5 | Blue colour output |

## Verification
The bench builds the block with its defaults: a 40x30 image centred on an 80x60 screen, with 10-bit coordinates. At this size the whole memory is filled and checked against a bench model in a few thousand cycles. Every window edge and the first position past each edge can be tested directly. The 10-bit coordinates still allow out-of-range writes far beyond the image, including those whose linear address would alias onto a real pixel. Read and write clocks are unrelated, and streaming reads with a new position every cycle expose the two-stage read latency.

// File: rtl/fb_pkg.sv
package fb_pkg;

    typedef struct packed {
        logic [4:0] r;
        logic [5:0] g;
        logic [4:0] b;
    } rgb565_t;

    localparam rgb565_t FB_BLACK = '0;

    // Linear pixel index inside the stored image
    function automatic logic [31:0] fb_lin_addr(input logic [31:0] x,
                                                input logic [31:0] y,
                                                input logic [31:0] w);
        return y * w + x;
    endfunction

    // True when v lies in [lo, lo+n)
    function automatic logic fb_in_span(input logic [31:0] v,
                                        input logic [31:0] lo,
                                        input logic [31:0] n);
        return (v >= lo) && (v < lo + n);
    endfunction

endpackage

// File: rtl/fb_wr_port.sv
module fb_wr_port
    import fb_pkg::*;
#(
    parameter int IMG_W   = 40,
    parameter int IMG_H   = 30,
    parameter int COORD_W = 10,
    parameter int ADDR_W  = 11
) (
    input  logic               wr_en,
    input  logic [COORD_W-1:0] wr_col,
    input  logic [COORD_W-1:0] wr_line,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr
);

    logic in_img;

    always_comb begin
        in_img   = fb_in_span(32'(wr_col), 32'd0, 32'(IMG_W)) &&
                   fb_in_span(32'(wr_line), 32'd0, 32'(IMG_H));
        mem_we   = wr_en && in_img;
        mem_addr = in_img ? ADDR_W'(fb_lin_addr(32'(wr_col), 32'(wr_line), 32'(IMG_W)))
                          : '0;
    end

endmodule

// File: rtl/fb_dp_ram.sv
module fb_dp_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1200,
    parameter int ADDR_W = 11
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rd_clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/fb_rd_view.sv
module fb_rd_view
    import fb_pkg::*;
#(
    parameter int IMG_W   = 40,
    parameter int IMG_H   = 30,
    parameter int SCR_W   = 80,
    parameter int SCR_H   = 60,
    parameter int COORD_W = 10,
    parameter int ADDR_W  = 11
) (
    input  logic               rd_clk,
    input  logic               rd_rst,
    input  logic [COORD_W-1:0] rd_col,
    input  logic [COORD_W-1:0] rd_line,
    input  logic               rd_blank,
    output logic [ADDR_W-1:0]  mem_raddr,
    input  logic [15:0]        mem_q,
    output rgb565_t            pix
);

    localparam int ORG_X = (SCR_W - IMG_W) / 2;
    localparam int ORG_Y = (SCR_H - IMG_H) / 2;

    logic in_win;
    logic show_q;

    // Stage 0: map the screen position to an image address
    always_comb begin
        in_win = fb_in_span(32'(rd_col), 32'(ORG_X), 32'(IMG_W)) &&
                 fb_in_span(32'(rd_line), 32'(ORG_Y), 32'(IMG_H));
        mem_raddr = in_win
                  ? ADDR_W'(fb_lin_addr(32'(rd_col) - 32'(ORG_X),
                                        32'(rd_line) - 32'(ORG_Y), 32'(IMG_W)))
                  : '0;
    end

    // Stage 1: visibility travels alongside the memory read
    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            show_q <= 1'b0;
        end else begin
            show_q <= in_win && !rd_blank;
        end
    end

    // Stage 2: registered colour output
    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            pix <= FB_BLACK;
        end else if (show_q) begin
            pix <= rgb565_t'(mem_q);
        end else begin
            pix <= FB_BLACK;
        end
    end

endmodule

// File: rtl/fb_qvga_window.sv
module fb_qvga_window
    import fb_pkg::*;
#(
    parameter int IMG_W   = 40,
    parameter int IMG_H   = 30,
    parameter int SCR_W   = 80,
    parameter int SCR_H   = 60,
    parameter int COORD_W = 10
) (
    input  logic               wr_clk,
    input  logic               wr_en,
    input  logic [COORD_W-1:0] wr_col,
    input  logic [COORD_W-1:0] wr_line,
    input  logic [15:0]        wr_data,
    input  logic               rd_clk,
    input  logic               rd_rst,
    input  logic [COORD_W-1:0] rd_col,
    input  logic [COORD_W-1:0] rd_line,
    input  logic               rd_blank,
    output logic [4:0]         out_r,
    output logic [5:0]         out_g,
    output logic [4:0]         out_b
);

    localparam int DEPTH  = IMG_W * IMG_H;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              wr_we;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [15:0]       rd_q;
    rgb565_t           pix;

    fb_wr_port #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .COORD_W(COORD_W), .ADDR_W(ADDR_W)
    ) i_wr (
        .wr_en   (wr_en),
        .wr_col  (wr_col),
        .wr_line (wr_line),
        .mem_we  (wr_we),
        .mem_addr(wr_addr)
    );

    fb_dp_ram #(
        .DATA_W(16), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
    ) i_ram (
        .wr_clk(wr_clk),
        .we    (wr_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .rd_clk(rd_clk),
        .raddr (rd_addr),
        .rdata (rd_q)
    );

    fb_rd_view #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .SCR_W(SCR_W), .SCR_H(SCR_H),
        .COORD_W(COORD_W), .ADDR_W(ADDR_W)
    ) i_rd (
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_col   (rd_col),
        .rd_line  (rd_line),
        .rd_blank (rd_blank),
        .mem_raddr(rd_addr),
        .mem_q    (rd_q),
        .pix      (pix)
    );

    assign out_r = pix.r;
    assign out_g = pix.g;
    assign out_b = pix.b;

endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
    parameter int IMG_W   = 40,
    parameter int IMG_H   = 30,
    parameter int SCR_W   = 80,
    parameter int SCR_H   = 60,
    parameter int COORD_W = 10
) (
    input logic               wr_clk,
    input logic               wr_we,
    input logic [COORD_W-1:0] wr_col,
    input logic [COORD_W-1:0] wr_line,
    input logic               rd_clk,
    input logic               rd_rst,
    input logic [COORD_W-1:0] rd_col,
    input logic [COORD_W-1:0] rd_line,
    input logic               rd_blank,
    input logic [4:0]         out_r,
    input logic [5:0]         out_g,
    input logic [4:0]         out_b
);

    localparam int ORG_X = (SCR_W - IMG_W) / 2;
    localparam int ORG_Y = (SCR_H - IMG_H) / 2;

    logic [1:0] age;
    logic       win;

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            age <= 2'd0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    assign win = (32'(rd_col) >= 32'(ORG_X)) && (32'(rd_col) < 32'(ORG_X + IMG_W)) &&
                 (32'(rd_line) >= 32'(ORG_Y)) && (32'(rd_line) < 32'(ORG_Y + IMG_H));

    AST_BLANK_BLACK: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (age == 2'd2 && $past(rd_blank, 2)) |-> ({out_r, out_g, out_b} == 16'd0)); // R5

    AST_OUTSIDE_BLACK: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (age == 2'd2 && !$past(win, 2)) |-> ({out_r, out_g, out_b} == 16'd0)); // R4

    AST_RESET_BLACK: assert property (@(posedge rd_clk)
        rd_rst |=> ({out_r, out_g, out_b} == 16'd0)); // R8

    AST_WR_INRANGE: assert property (@(posedge wr_clk)
        wr_we |-> (32'(wr_col) < 32'(IMG_W) && 32'(wr_line) < 32'(IMG_H))); // R2

endmodule

bind fb_qvga_window fb_checker #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .SCR_W(SCR_W), .SCR_H(SCR_H), .COORD_W(COORD_W)
) u_fb_checker (
    .wr_clk  (wr_clk),
    .wr_we   (wr_we),
    .wr_col  (wr_col),
    .wr_line (wr_line),
    .rd_clk  (rd_clk),
    .rd_rst  (rd_rst),
    .rd_col  (rd_col),
    .rd_line (rd_line),
    .rd_blank(rd_blank),
    .out_r   (out_r),
    .out_g   (out_g),
    .out_b   (out_b)
);

// File: tb/test_fb_qvga_window.sv
module test_fb_qvga_window;

    localparam int IMG_W   = 40;
    localparam int IMG_H   = 30;
    localparam int SCR_W   = 80;
    localparam int SCR_H   = 60;
    localparam int COORD_W = 10;
    localparam int ORG_X   = (SCR_W - IMG_W) / 2;
    localparam int ORG_Y   = (SCR_H - IMG_H) / 2;
    localparam int NPIX    = IMG_W * IMG_H;

    logic               wr_clk = 1'b0;
    logic               rd_clk = 1'b0;
    logic               wr_en = 1'b0;
    logic [COORD_W-1:0] wr_col = '0;
    logic [COORD_W-1:0] wr_line = '0;
    logic [15:0]        wr_data = '0;
    logic               rd_rst = 1'b1;
    logic [COORD_W-1:0] rd_col = '0;
    logic [COORD_W-1:0] rd_line = '0;
    logic               rd_blank = 1'b1;
    logic [4:0]         out_r;
    logic [5:0]         out_g;
    logic [4:0]         out_b;

    logic [15:0] model [NPIX];
    int checks = 0;
    int errors = 0;

    always #5    rd_clk = ~rd_clk;
    always #18.5 wr_clk = ~wr_clk;

    fb_qvga_window #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .SCR_W(SCR_W), .SCR_H(SCR_H), .COORD_W(COORD_W)
    ) i_fb_qvga_window (
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_col(wr_col), .wr_line(wr_line),
        .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_col(rd_col),
        .rd_line(rd_line), .rd_blank(rd_blank),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic logic [15:0] exp_px(int c, int l, logic blk);
        if (blk) return 16'd0;
        if (c < ORG_X || c >= ORG_X + IMG_W || l < ORG_Y || l >= ORG_Y + IMG_H) return 16'd0;
        return model[(l - ORG_Y) * IMG_W + (c - ORG_X)];
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_px(int c, int l, logic [15:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_col = COORD_W'(c); wr_line = COORD_W'(l); wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
        if (c < IMG_W && l < IMG_H) model[l * IMG_W + c] = d;
    endtask

    task automatic rd_px(int c, int l, logic blk, output logic [15:0] got);
        @(negedge rd_clk);
        rd_col = COORD_W'(c); rd_line = COORD_W'(l); rd_blank = blk;
        @(posedge rd_clk);
        @(posedge rd_clk);
        @(negedge rd_clk);
        got = {out_r, out_g, out_b};
    endtask

    task automatic rd_chk(string req, int c, int l, logic blk);
        logic [15:0] got;
        rd_px(c, l, blk, got);
        check(req, got, exp_px(c, l, blk));
    endtask

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] got;
        logic [15:0] first [64];
        int pc [64];
        int pl [64];
        int sc [10];
        int sl [10];
        logic sb [10];
        void'($urandom(32'd4242));

        // R8: reset state
        repeat (3) @(posedge rd_clk);
        @(negedge rd_clk);
        check("R8 reset black", {out_r, out_g, out_b}, 16'd0);
        rd_rst = 1'b0;

        // R1: fill the whole image
        for (int l = 0; l < IMG_H; l++)
            for (int c = 0; c < IMG_W; c++)
                wr_px(c, l, 16'($urandom));

        // R3: window corners and edges
        rd_chk("R3 top-left", ORG_X, ORG_Y, 1'b0);
        rd_chk("R3 top-right", ORG_X + IMG_W - 1, ORG_Y, 1'b0);
        rd_chk("R3 bottom-left", ORG_X, ORG_Y + IMG_H - 1, 1'b0);
        rd_chk("R3 bottom-right", ORG_X + IMG_W - 1, ORG_Y + IMG_H - 1, 1'b0);
        // R4: just outside each edge
        rd_chk("R4 left", ORG_X - 1, ORG_Y, 1'b0);
        rd_chk("R4 right", ORG_X + IMG_W, ORG_Y, 1'b0);
        rd_chk("R4 above", ORG_X, ORG_Y - 1, 1'b0);
        rd_chk("R4 below", ORG_X, ORG_Y + IMG_H, 1'b0);
        rd_chk("R4 origin", 0, 0, 1'b0);
        // R5: blanking inside the window
        rd_chk("R5 blank inside", ORG_X + 3, ORG_Y + 3, 1'b1);

        // R6: field split of a known word
        wr_px(5, 6, 16'b10101_110011_01110);
        rd_px(ORG_X + 5, ORG_Y + 6, 1'b0, got);
        check("R6 red", 16'(out_r), 16'(5'b10101));
        check("R6 green", 16'(out_g), 16'(6'b110011));
        check("R6 blue", 16'(out_b), 16'(5'b01110));

        // R2: out-of-range writes, including one that would alias onto line 1
        wr_px(IMG_W, 0, 16'hDEAD);
        rd_chk("R2 alias col", ORG_X, ORG_Y + 1, 1'b0);
        wr_px(0, IMG_H, 16'hBEEF);
        wr_px(IMG_W + 7, 2, 16'h1234);
        rd_chk("R2 col overflow", ORG_X + 7, ORG_Y + 3, 1'b0);
        for (int i = 0; i < 20; i++)
            wr_px(IMG_W + int'($urandom_range(0, 900)), int'($urandom_range(0, 1000)), 16'($urandom));
        for (int i = 0; i < 20; i++)
            rd_chk("R2 random ignored", ORG_X + int'($urandom_range(0, IMG_W - 1)),
                   ORG_Y + int'($urandom_range(0, IMG_H - 1)), 1'b0);

        // R1: random in-range writes, then random reads over the whole screen
        for (int i = 0; i < 200; i++)
            wr_px(int'($urandom_range(0, IMG_W - 1)), int'($urandom_range(0, IMG_H - 1)), 16'($urandom));
        for (int i = 0; i < 300; i++)
            rd_chk("R1 random read", int'($urandom_range(0, SCR_W - 1)),
                   int'($urandom_range(0, SCR_H - 1)), ($urandom_range(0, 7) == 0));

        // R7: streaming, one new position per cycle, two-cycle lag
        for (int i = 0; i < 10; i++) begin
            sc[i] = ORG_X - 2 + int'($urandom_range(0, IMG_W + 3));
            sl[i] = ORG_Y - 1 + int'($urandom_range(0, IMG_H + 1));
            sb[i] = ($urandom_range(0, 4) == 0);
        end
        for (int i = 0; i < 12; i++) begin
            @(negedge rd_clk);
            if (i >= 2) check("R7 stream lag", {out_r, out_g, out_b}, exp_px(sc[i-2], sl[i-2], sb[i-2]));
            if (i < 10) begin
                rd_col = COORD_W'(sc[i]); rd_line = COORD_W'(sl[i]); rd_blank = sb[i];
            end
        end

        // R9: two scans of an unchanged frame agree
        for (int i = 0; i < 64; i++) begin
            pc[i] = ORG_X + int'($urandom_range(0, IMG_W - 1));
            pl[i] = ORG_Y + int'($urandom_range(0, IMG_H - 1));
            rd_px(pc[i], pl[i], 1'b0, first[i]);
        end
        for (int i = 0; i < 64; i++) begin
            rd_px(pc[i], pl[i], 1'b0, got);
            check("R9 rescan", got, first[i]);
        end

        // R8: reset mid-run, then memory still holds the frame
        @(negedge rd_clk);
        rd_rst = 1'b1; rd_col = COORD_W'(ORG_X); rd_line = COORD_W'(ORG_Y); rd_blank = 1'b0;
        @(posedge rd_clk);
        @(negedge rd_clk);
        check("R8 reset clears", {out_r, out_g, out_b}, 16'd0);
        rd_rst = 1'b0;
        rd_chk("R8 memory kept", ORG_X + IMG_W - 1, ORG_Y, 1'b0);
        rd_chk("R8 memory kept", ORG_X + 5, ORG_Y + 6, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule